// File: doc/BRIEF.md
# Serial Lane Line-Rate Retuning Sequencer

This block moves one lane of a multi-rate serial transceiver to a new line rate. A caller presents a 3-bit rate code and a receive-equalizer mode bit (low-power or decision-feedback) with a one-cycle request. The block then works through a fixed list of seven configuration fields over a dynamic reconfiguration port. Each field is a read-modify-write: the register is read, only the field's bits are replaced, and the word is written back. Once the last write is acknowledged, the block asks an external reset sequencer to reset the transceiver. It raises done when that sequencer reports completion.

The top rate and its halves and quarters run from the shared PLL, which is parked at the top rate, with output dividers of 1, 2 or 4. The two rates that are not power-of-two fractions of the top rate run from the lane's own PLL, and that PLL is powered down whenever the shared one is in use. Each switch rewrites the recovery and equalizer words, which depend on the rate, together with the mode fields. The reset it requests is a full reset starting at the analog level whenever the equalizer mode changes. A port access that is never acknowledged aborts the switch with an error and issues no reset.

Top module: `lane_rate_retuner`

## Requirements
- R1: Rate codes 0..4 select 2.4576, 3.072, 4.9152, 6.144 and 9.8304 Gbps. A request with code 5, 6 or 7 makes error high for exactly one cycle, in the cycle after the request. busy stays low, and no port access and no reset request follow.
- R2: An accepted switch performs seven read-modify-write steps in this order: CDR word (address 0x0A8, mask 0x00FFFFFF), bias word (0x095, mask 0x00000030), equalizer word 2 (0x01D, mask 0x07FFFFFF), DFE/LPM word (0x029, mask 0x0000003C), RX divider (0x088, mask 0x00000007), TX divider (0x088, mask 0x00000070), PLL select (0x05E, mask 0x00000003). Each step reads the address, then writes (read_data & ~mask) | (value & mask) to the same address.
- R3: The CDR field value is 0x00C00040 + 0x110 × rate code. The low 23 bits of equalizer word 2 are 0x1A0 + 0x20 × rate code.
- R4: With the DFE mode bit set, bias bits [5:4] = 2'b11, equalizer word-2 bits [26:23] = 4'b0111 and DFE/LPM bits [5:2] = 4'b0010. In low-power mode all three fields are written as zero.
- R5: The RX divider field (bits [2:0]) and the TX divider field (bits [6:4]) both take code 2 (divide by 4) for rate 0, code 1 (divide by 2) for rates 1 and 2, and code 0 (divide by 1) for rates 3 and 4.
- R6: PLL select bits [1:0] are 2'b01 (lane PLL in use, shared PLL kept) for rates 1 and 3. For the other rates they are 2'b10 (shared PLL in use, lane PLL powered down).
- R7: The reset request is high for exactly one cycle, and only after the seventh write has been acknowledged. There is no port access between the reset request and done.
- R8: The full-reset flag is high with the reset request exactly when the requested mode differs from the mode of the last switch that completed. The remembered mode after reset is low-power.
- R9: busy is high from the cycle after an accepted request until the cycle in which done or error goes high. done is high for one cycle, in the cycle after the reset sequencer's done input is seen.
- R10: An access whose ready arrives within 256 cycles after its enable cycle proceeds. If ready is still absent in the 256th cycle, the switch aborts: error pulses, busy falls, no reset is requested, and the remembered mode is unchanged.
- R11: A request that arrives while busy is high is ignored and causes no further accesses.
- R12: The port enable lasts one cycle, and no new access starts while one is awaiting ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle switch request |
| req_rate | input | 3 | Target rate code |
| req_dfe | input | 1 | 1 = decision-feedback equalizer mode, 0 = low-power mode |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle pulse on completion |
| error | output | 1 | One-cycle pulse on invalid code or port timeout |
| drp_addr | output | ADDR_W | Reconfiguration port address |
| drp_di | output | DATA_W | Reconfiguration port write data |
| drp_en | output | 1 | Access enable |
| drp_we | output | 1 | Write enable (with drp_en) |
| drp_do | input | DATA_W | Read data, valid with drp_rdy |
| drp_rdy | input | 1 | Access acknowledge |
| xcvr_rst_req | output | 1 | Reset request to the reset sequencer |
| xcvr_rst_full | output | 1 | Full (analog-level) reset wanted, valid with xcvr_rst_req |
| xcvr_rst_done | input | 1 | Reset sequencer completion |

## Verification
Some properties are checked on every cycle: the one-cycle enable and the single outstanding access, the quiet port and reset outputs while idle, the one-cycle reset request, done always following the reset sequencer's completion, busy ending only together with done or error, and the bound on waiting for ready. Other behaviour shows only in the bench's scenarios. These cover the per-rate field values and the merging of masked bits into the read data, the order of the seven steps, and the full-reset flag across a chain of mode changes. They also cover that a timed-out switch leaves the remembered mode untouched, and that invalid codes and requests arriving while busy have no effect. The ready latency is exercised on both sides of the 256-cycle limit.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

   localparam int RATE_W    = 3;
   localparam int NUM_RATES = 5;
   localparam int NUM_STEPS = 7;
   localparam int STEP_W    = $clog2(NUM_STEPS);

   // Output divider code for a rate: 2 = /4, 1 = /2, 0 = /1
   function automatic logic [2:0] div_code(input logic [RATE_W-1:0] r);
      case (r)
         3'd0:       return 3'd2;
         3'd1, 3'd2: return 3'd1;
         default:    return 3'd0;
      endcase
   endfunction

   // Rates that are not power-of-two fractions of the top rate
   function automatic logic per_lane(input logic [RATE_W-1:0] r);
      return (r == 3'd1) || (r == 3'd3);
   endfunction

   function automatic logic [8:0] step_addr(input int s);
      case (s)
         0:       return 9'h0A8;
         1:       return 9'h095;
         2:       return 9'h01D;
         3:       return 9'h029;
         4, 5:    return 9'h088;
         6:       return 9'h05E;
         default: return 9'h000;
      endcase
   endfunction

   function automatic logic [31:0] step_mask(input int s);
      case (s)
         0:       return 32'h00FF_FFFF;
         1:       return 32'h0000_0030;
         2:       return 32'h07FF_FFFF;
         3:       return 32'h0000_003C;
         4:       return 32'h0000_0007;
         5:       return 32'h0000_0070;
         6:       return 32'h0000_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [31:0] step_value(input int s, input logic [RATE_W-1:0] r,
                                              input logic dfe);
      logic [31:0] rz;
      rz = {29'd0, r};
      case (s)
         0:       return 32'h00C0_0040 + 32'h0000_0110 * rz;
         1:       return dfe ? 32'h0000_0030 : 32'h0000_0000;
         2:       return {5'd0, (dfe ? 4'b0111 : 4'b0000), 23'(32'h1A0 + 32'h20 * rz)};
         3:       return dfe ? 32'h0000_0008 : 32'h0000_0000;
         4:       return {29'd0, div_code(r)};
         5:       return {25'd0, div_code(r), 4'd0};
         6:       return per_lane(r) ? 32'h0000_0001 : 32'h0000_0002;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/lrr_step_rom.sv
module lrr_step_rom
   import lrr_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 32
)(
   input  logic [STEP_W-1:0] step,
   input  logic [RATE_W-1:0] rate,
   input  logic              dfe,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] value
);

   if (ADDR_W < 9)  begin : g_bad_addr $error("lrr_step_rom: ADDR_W must be at least 9"); end
   if (DATA_W < 32) begin : g_bad_data $error("lrr_step_rom: DATA_W must be at least 32"); end

   logic [ADDR_W-1:0] tbl_addr [NUM_STEPS];
   logic [DATA_W-1:0] tbl_mask [NUM_STEPS];
   logic [DATA_W-1:0] tbl_val  [NUM_STEPS];

   for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
      assign tbl_addr[g] = ADDR_W'(step_addr(g));
      assign tbl_mask[g] = DATA_W'(step_mask(g));
      assign tbl_val[g]  = DATA_W'(step_value(g, rate, dfe));
   end

   always_comb begin
      addr  = '0;
      mask  = '0;
      value = '0;
      for (int i = 0; i < NUM_STEPS; i++) begin
         if (step == STEP_W'(i)) begin
            addr  = tbl_addr[i];
            mask  = tbl_mask[i];
            value = tbl_val[i];
         end
      end
   end

endmodule

// File: rtl/lrr_rmw_engine.sv
module lrr_rmw_engine #(
   parameter int ADDR_W  = 9,
   parameter int DATA_W  = 32,
   parameter int TIMEOUT = 256
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] mask_in,
   input  logic [DATA_W-1:0] val_in,
   output logic [ADDR_W-1:0] drp_addr,
   output logic [DATA_W-1:0] drp_di,
   output logic              drp_en,
   output logic              drp_we,
   input  logic [DATA_W-1:0] drp_do,
   input  logic              drp_rdy,
   output logic              finish,
   output logic              timeout
);

   if (TIMEOUT < 2) begin : g_bad_to $error("lrr_rmw_engine: TIMEOUT must be at least 2"); end

   localparam int CNT_W = $clog2(TIMEOUT);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

   typedef enum logic [2:0] {E_IDLE, E_RD, E_RD_WAIT, E_WR, E_WR_WAIT} eng_e;

   eng_e              st;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] mask_q, val_q, wdata_q;
   logic [CNT_W-1:0]  cnt;

   assign drp_en   = (st == E_RD) || (st == E_WR);
   assign drp_we   = (st == E_WR);
   assign drp_addr = addr_q;
   assign drp_di   = wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= E_IDLE;
         addr_q  <= '0;
         mask_q  <= '0;
         val_q   <= '0;
         wdata_q <= '0;
         cnt     <= '0;
         finish  <= 1'b0;
         timeout <= 1'b0;
      end else begin
         finish  <= 1'b0;
         timeout <= 1'b0;
         case (st)
            E_IDLE: if (start) begin
               addr_q <= addr_in;
               mask_q <= mask_in;
               val_q  <= val_in;
               st     <= E_RD;
            end
            E_RD: begin
               cnt <= '0;
               st  <= E_RD_WAIT;
            end
            E_RD_WAIT: begin
               if (drp_rdy) begin
                  wdata_q <= (drp_do & ~mask_q) | (val_q & mask_q);
                  st      <= E_WR;
               end else if (cnt == CNT_LAST) begin
                  timeout <= 1'b1;
                  st      <= E_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            E_WR: begin
               cnt <= '0;
               st  <= E_WR_WAIT;
            end
            E_WR_WAIT: begin
               if (drp_rdy) begin
                  finish <= 1'b1;
                  st     <= E_IDLE;
               end else if (cnt == CNT_LAST) begin
                  timeout <= 1'b1;
                  st      <= E_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lane_rate_retuner.sv
module lane_rate_retuner
   import lrr_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int DATA_W   = 32,
   parameter int TIMEOUT  = 256,
   parameter bit INIT_DFE = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [2:0]        req_rate,
   input  logic              req_dfe,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [ADDR_W-1:0] drp_addr,
   output logic [DATA_W-1:0] drp_di,
   output logic              drp_en,
   output logic              drp_we,
   input  logic [DATA_W-1:0] drp_do,
   input  logic              drp_rdy,
   output logic              xcvr_rst_req,
   output logic              xcvr_rst_full,
   input  logic              xcvr_rst_done
);

   if (ADDR_W < 9)   begin : g_bad_addr $error("lane_rate_retuner: ADDR_W must be at least 9"); end
   if (DATA_W < 32)  begin : g_bad_data $error("lane_rate_retuner: DATA_W must be at least 32"); end
   if (TIMEOUT < 2)  begin : g_bad_to   $error("lane_rate_retuner: TIMEOUT must be at least 2"); end

   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
   localparam logic [RATE_W-1:0] MAX_RATE  = RATE_W'(NUM_RATES - 1);

   typedef enum logic [1:0] {S_IDLE, S_UPDATE, S_RESET, S_WAIT} seq_e;

   seq_e              st;
   logic [STEP_W-1:0] step_q;
   logic [RATE_W-1:0] rate_q;
   logic              dfe_q, cur_dfe;
   logic              start_q, done_q, err_q;

   logic [ADDR_W-1:0] rom_addr;
   logic [DATA_W-1:0] rom_mask, rom_val;
   logic              eng_finish, eng_timeout;

   lrr_step_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
      .step  (step_q),
      .rate  (rate_q),
      .dfe   (dfe_q),
      .addr  (rom_addr),
      .mask  (rom_mask),
      .value (rom_val)
   );

   lrr_rmw_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_q),
      .addr_in  (rom_addr),
      .mask_in  (rom_mask),
      .val_in   (rom_val),
      .drp_addr (drp_addr),
      .drp_di   (drp_di),
      .drp_en   (drp_en),
      .drp_we   (drp_we),
      .drp_do   (drp_do),
      .drp_rdy  (drp_rdy),
      .finish   (eng_finish),
      .timeout  (eng_timeout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         step_q  <= '0;
         rate_q  <= '0;
         dfe_q   <= INIT_DFE;
         cur_dfe <= INIT_DFE;
         start_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         case (st)
            S_IDLE: if (req) begin
               if (req_rate > MAX_RATE) begin
                  err_q <= 1'b1;
               end else begin
                  rate_q  <= req_rate;
                  dfe_q   <= req_dfe;
                  step_q  <= '0;
                  start_q <= 1'b1;
                  st      <= S_UPDATE;
               end
            end
            S_UPDATE: begin
               if (eng_timeout) begin
                  err_q <= 1'b1;
                  st    <= S_IDLE;
               end else if (eng_finish) begin
                  if (step_q == LAST_STEP) begin
                     st <= S_RESET;
                  end else begin
                     step_q  <= step_q + 1'b1;
                     start_q <= 1'b1;
                  end
               end
            end
            S_RESET: st <= S_WAIT;
            S_WAIT: if (xcvr_rst_done) begin
               done_q  <= 1'b1;
               cur_dfe <= dfe_q;
               st      <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy          = (st != S_IDLE);
   assign done          = done_q;
   assign error         = err_q;
   assign xcvr_rst_req  = (st == S_RESET);
   assign xcvr_rst_full = (st == S_RESET) && (dfe_q != cur_dfe);

endmodule

// File: rtl/lrr_checker.sv
module lrr_checker #(
   parameter int TIMEOUT = 256
)(
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic error,
   input logic drp_en,
   input logic drp_rdy,
   input logic xcvr_rst_req,
   input logic xcvr_rst_done
);

   localparam int CW = $clog2(TIMEOUT + 4) + 1;

   logic          pend;
   logic [CW-1:0] wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         wcnt <= '0;
      end else if (drp_en) begin
         pend <= 1'b1;
         wcnt <= '0;
      end else if (pend) begin
         if (drp_rdy || !busy) pend <= 1'b0;
         else if (wcnt != '1) wcnt <= wcnt + 1'b1;
      end
   end

   p_en_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      drp_en |=> !drp_en);

   p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> !drp_en);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!drp_en && !xcvr_rst_req));

   p_rst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xcvr_rst_req |=> !xcvr_rst_req);

   p_done_after_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(xcvr_rst_done));

   p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || error));

   p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !busy);

   p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && (wcnt > CW'(TIMEOUT))) |-> !busy);

endmodule

bind lane_rate_retuner lrr_checker #(.TIMEOUT(TIMEOUT)) u_lrr_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .done          (done),
   .error         (error),
   .drp_en        (drp_en),
   .drp_rdy       (drp_rdy),
   .xcvr_rst_req  (xcvr_rst_req),
   .xcvr_rst_done (xcvr_rst_done)
);

// File: tb/lane_rate_retuner_tb_top.sv
`timescale 1ns/1ps
module lane_rate_retuner_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [2:0]  req_rate = 3'd0;
   logic        req_dfe = 1'b0;
   logic        busy, done, error;
   logic [8:0]  drp_addr;
   logic [31:0] drp_di;
   logic        drp_en, drp_we;
   logic [31:0] drp_do = 32'd0;
   logic        drp_rdy = 1'b0;
   logic        xcvr_rst_req, xcvr_rst_full;
   logic        xcvr_rst_done = 1'b0;

   always #2 clk = ~clk;

   lane_rate_retuner dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .req_rate(req_rate), .req_dfe(req_dfe),
      .busy(busy), .done(done), .error(error),
      .drp_addr(drp_addr), .drp_di(drp_di), .drp_en(drp_en), .drp_we(drp_we),
      .drp_do(drp_do), .drp_rdy(drp_rdy),
      .xcvr_rst_req(xcvr_rst_req), .xcvr_rst_full(xcvr_rst_full),
      .xcvr_rst_done(xcvr_rst_done)
   );

   int total = 0;
   int bad   = 0;
   int en_cnt = 0, rst_cnt = 0;

   task automatic chk(input bit ok, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", what, act, exp);
      end
   endtask

   // ---------------- expected values from the requirements ----------------
   function automatic logic [8:0] b_addr(input int s);
      if (s == 0) return 9'h0A8;
      if (s == 1) return 9'h095;
      if (s == 2) return 9'h01D;
      if (s == 3) return 9'h029;
      if (s == 6) return 9'h05E;
      return 9'h088;
   endfunction

   function automatic logic [31:0] b_mask(input int s);
      logic [31:0] m [7] = '{32'h00FFFFFF, 32'h30, 32'h07FFFFFF, 32'h3C, 32'h7, 32'h70, 32'h3};
      return m[s];
   endfunction

   function automatic logic [31:0] b_val(input int s, input int r, input bit dfe);
      int dv;
      dv = (r == 0) ? 2 : ((r <= 2) ? 1 : 0);
      if (s == 0) return 32'hC00040 + 32'(r) * 32'h110;           // R3
      if (s == 1) return dfe ? 32'h30 : 32'h0;                     // R4
      if (s == 2) return (dfe ? 32'h03800000 : 32'h0) + 32'h1A0 + 32'(r) * 32'h20; // R3 R4
      if (s == 3) return dfe ? 32'h8 : 32'h0;                      // R4
      if (s == 4) return 32'(dv);                                  // R5
      if (s == 5) return 32'(dv) << 4;                             // R5
      return (r == 1 || r == 3) ? 32'h1 : 32'h2;                   // R6
   endfunction

   function automatic string tag_of(input int s);
      if (s == 0 || s == 2) return "R2/R3";
      if (s == 1 || s == 3) return "R2/R4";
      if (s == 6) return "R2/R6";
      return "R2/R5";
   endfunction

   typedef struct {
      logic [8:0]  addr;
      logic [31:0] data;
      int          step;
   } exp_item_t;

   exp_item_t   exp_q[$];
   bit          full_q[$];
   logic [31:0] sh_regs [512];
   logic [31:0] mregs   [512];

   // driver side of the scoreboard
   task automatic push_expect(input int r, input bit dfe, input bit commit);
      logic [31:0] save [7];
      for (int s = 0; s < 7; s++) save[s] = sh_regs[b_addr(s)];
      for (int s = 0; s < 7; s++) begin
         logic [8:0]  a;
         logic [31:0] nv;
         a  = b_addr(s);
         nv = (sh_regs[a] & ~b_mask(s)) | (b_val(s, r, dfe) & b_mask(s));
         sh_regs[a] = nv;
         exp_q.push_back('{addr: a, data: nv, step: s});
      end
      if (!commit)
         for (int s = 6; s >= 0; s--) sh_regs[b_addr(s)] = save[s];
   endtask

   // ---------------- reconfiguration port model ----------------
   int         lat = 2;
   bit         mpend = 1'b0;
   int         mcnt = 0;
   logic [8:0] maddr = 9'd0;

   initial begin
      for (int i = 0; i < 512; i++) begin
         mregs[i]   = 32'h5A3C0F00 ^ (32'(i) * 32'h00010203);
         sh_regs[i] = 32'h5A3C0F00 ^ (32'(i) * 32'h00010203);
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         drp_rdy <= 1'b0;
         if (mpend) begin
            if (mcnt <= 1) begin
               drp_rdy <= 1'b1;
               drp_do  <= mregs[maddr];
               mpend   <= 1'b0;
            end else begin
               mcnt <= mcnt - 1;
            end
         end
         if (drp_en) begin
            mpend <= 1'b1;
            mcnt  <= lat;
            maddr <= drp_addr;
            if (drp_we) mregs[drp_addr] <= drp_di;
         end
      end
   end

   // reset sequencer model
   int rcnt = 0;
   always @(posedge clk) begin
      xcvr_rst_done <= 1'b0;
      if (xcvr_rst_req) rcnt <= 5;
      else if (rcnt > 0) begin
         rcnt <= rcnt - 1;
         if (rcnt == 1) xcvr_rst_done <= 1'b1;
      end
   end

   // ---------------- monitor ----------------
   bit prev_rst_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (drp_en) begin
            en_cnt++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R12 access with nothing expected", 32'(drp_addr), 32'h0);
            end else if (!drp_we) begin
               chk(drp_addr == exp_q[0].addr, {tag_of(exp_q[0].step), " read address"},
                   32'(drp_addr), 32'(exp_q[0].addr));
            end else begin
               exp_item_t it;
               it = exp_q.pop_front();
               chk(drp_addr == it.addr, {tag_of(it.step), " write address"},
                   32'(drp_addr), 32'(it.addr));
               chk(drp_di == it.data, {tag_of(it.step), " write data"}, drp_di, it.data);
            end
         end
         if (xcvr_rst_req) begin
            rst_cnt++;
            chk(exp_q.size() == 0, "R7 reset before all writes", 32'(exp_q.size()), 32'h0);
            if (full_q.size() == 0)
               chk(1'b0, "R7 unexpected reset request", 32'h1, 32'h0);
            else begin
               bit f;
               f = full_q.pop_front();
               chk(xcvr_rst_full == f, "R8 full reset flag", 32'(xcvr_rst_full), 32'(f));
            end
         end
         if (done)
            chk(prev_rst_done, "R9 done without prior reset completion", 32'(prev_rst_done), 32'h1);
         prev_rst_done = xcvr_rst_done;
      end
   end

   // ---------------- scenarios ----------------
   task automatic pulse_req(input int r, input bit dfe);
      @(negedge clk);
      req_rate = 3'(r);
      req_dfe  = dfe;
      req      = 1'b1;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic run_switch(input int r, input bit dfe, input bit full, input bit intrude);
      int e0, r0, i;
      e0 = en_cnt;
      r0 = rst_cnt;
      push_expect(r, dfe, 1'b1);
      full_q.push_back(full);
      pulse_req(r, dfe);
      chk(busy == 1'b1, "R9 busy after accepted request", 32'(busy), 32'h1);
      if (intrude) begin
         repeat (5) @(negedge clk);
         req_rate = 3'd4;
         req_dfe  = ~dfe;
         req      = 1'b1;                           // R11: must be ignored
         @(negedge clk);
         req = 1'b0;
      end
      i = 0;
      while (!done && !error && i < 20000) begin
         @(negedge clk);
         i++;
      end
      chk(done == 1'b1, "R9 done seen", 32'(done), 32'h1);
      chk(busy == 1'b0, "R9 busy low with done", 32'(busy), 32'h0);
      @(negedge clk);
      chk(done == 1'b0, "R9 done lasts one cycle", 32'(done), 32'h0);
      repeat (30) @(negedge clk);
      chk(en_cnt == e0 + 14, "R11/R12 access count", 32'(en_cnt - e0), 32'd14);
      chk(rst_cnt == r0 + 1, "R7 one reset request", 32'(rst_cnt - r0), 32'd1);
      chk(busy == 1'b0, "R11 idle after switch", 32'(busy), 32'h0);
   endtask

   task automatic run_invalid(input int r);
      int e0, r0;
      e0 = en_cnt;
      r0 = rst_cnt;
      pulse_req(r, 1'b1);
      chk(error == 1'b1, "R1 error on invalid code", 32'(error), 32'h1);
      chk(busy == 1'b0, "R1 busy stays low", 32'(busy), 32'h0);
      @(negedge clk);
      chk(error == 1'b0, "R1 error one cycle", 32'(error), 32'h0);
      repeat (10) @(negedge clk);
      chk(en_cnt == e0, "R1 no access", 32'(en_cnt - e0), 32'h0);
      chk(rst_cnt == r0, "R1 no reset", 32'(rst_cnt - r0), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R9 reset busy", 32'(busy), 32'h0);
      chk(done == 1'b0 && error == 1'b0, "R9 reset done/error", 32'({done, error}), 32'h0);
      chk(drp_en == 1'b0 && xcvr_rst_req == 1'b0, "R12 reset outputs quiet",
          32'({drp_en, xcvr_rst_req}), 32'h0);

      run_switch(4, 1'b1, 1'b1, 1'b0);   // R1 R8: LPM -> DFE, top rate, shared PLL
      run_switch(2, 1'b1, 1'b0, 1'b0);   // R5: divide by 2, same mode
      run_switch(1, 1'b0, 1'b1, 1'b0);   // R6: lane PLL, mode back to LPM
      run_switch(3, 1'b0, 1'b0, 1'b0);   // R6: lane PLL, /1
      run_switch(0, 1'b1, 1'b1, 1'b0);   // R5: divide by 4
      run_switch(2, 1'b0, 1'b1, 1'b1);   // R11: request during busy ignored

      run_invalid(5);                    // R1
      run_invalid(7);                    // R1

      lat = 255;                         // R10: ready in the 256th cycle is accepted
      run_switch(4, 1'b0, 1'b0, 1'b0);

      begin                              // R10: ready one cycle too late aborts
         int e0, r0, i;
         e0  = en_cnt;
         r0  = rst_cnt;
         lat = 256;
         push_expect(3, 1'b1, 1'b0);
         pulse_req(3, 1'b1);
         i = 0;
         while (!error && i < 2000) begin
            @(negedge clk);
            i++;
         end
         chk(error == 1'b1, "R10 timeout error", 32'(error), 32'h1);
         chk(busy == 1'b0, "R10 busy low on abort", 32'(busy), 32'h0);
         exp_q.delete();
         repeat (400) @(negedge clk);
         chk(en_cnt == e0 + 1, "R10 abort after first access", 32'(en_cnt - e0), 32'h1);
         chk(rst_cnt == r0, "R10 no reset on abort", 32'(rst_cnt - r0), 32'h0);
      end

      lat = 2;
      run_switch(3, 1'b0, 1'b0, 1'b0);   // R8 R10: remembered mode still LPM

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule